// File: doc/BRIEF.md
# Sub-Word Register Write Merger

This block connects a bus that issues byte, halfword and word accesses to a register block that only accepts full 32-bit words at word-aligned addresses. Word accesses pass through unchanged in one cycle. A narrow read fetches the containing word and returns it shifted right so that the addressed lane sits at bit 0.

The handling of a narrow write depends on the class of the target register. For a plain read/write register, the block reads the current word, replaces the addressed lane, and writes the merged word back. This takes two downstream cycles, and the upstream side is stalled with `up_ready` until the write has been issued. For registers where writing a one triggers an action (write-one-to-clear flags and set/clear aliases), the block does not merge. It writes the lane data shifted into place with zeros everywhere else, so that untouched bits cannot clear or set anything. Narrow writes to read-only or unmapped words are dropped.

The address map used for classification has these word-aligned byte offsets:
- read-only: 0x00 to 0x08
- read/write: 0x10 to 0x2C
- write-one-to-clear: 0x30 to 0x34
- set/clear alias: 0x40 to 0x4C

Every other offset is unmapped.

Top module: `sw_merge_bridge`

## Requirements
- R1: After reset, with no request pending, `dn_valid` is 0 and `up_ready` is 1, and the first narrow read/write access starts with its read phase.
- R2: A word access (`up_size`=2) is forwarded in the same cycle with `up_ready`=1. It goes to the word-aligned address, carries unchanged write data, returns `dn_rdata` unchanged, and applies to every offset, read-only ones included.
- R3: A narrow read (`up_size`=0 byte, 1 halfword) completes in one cycle and returns the word at the aligned address shifted right by `up_addr[1:0]`×8.
- R4: A narrow write to a read/write register (0x10 to 0x2C) writes back `(old & ~(M<<S)) | ((up_wdata & M)<<S)`, where M is 0xFF for a byte access and 0xFFFF for a halfword access, S is `up_addr[1:0]`×8, and write-data bits above the access width are ignored.
- R5: That read-modify-write takes two cycles. In the first cycle there is a downstream read with `up_ready`=0. In the second there is a downstream write with `up_ready`=1.
- R6: A narrow write to a write-one-to-clear register (0x30 to 0x34) is one downstream write of `(up_wdata & M)<<S` with zeros outside the lane, issued in one cycle.
- R7: A narrow write to a set/clear alias (0x40 to 0x4C) is one zero-filled downstream write, as in R6, issued in one cycle.
- R8: A narrow write to a read-only offset (0x00 to 0x08) causes no downstream write.
- R9: A narrow write to an unmapped offset causes no downstream write and completes in one cycle.
- R10: A halfword access with `up_addr[0]`=1 is misaligned. It causes no downstream access, a read returns 0, and it completes in one cycle.
- R11: The reserved size code 3 is treated like R10: no downstream access, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request present |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| up_addr | input | ADDR_W | Byte address |
| up_wdata | input | 32 | Write data; narrow data in the low bits |
| up_ready | output | 1 | Request completes this cycle |
| up_rdata | output | 32 | Read data, lane shifted to bit 0 |
| dn_valid | output | 1 | Downstream access this cycle |
| dn_write | output | 1 | Downstream write when 1 |
| dn_addr | output | ADDR_W | Word-aligned downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid in the cycle of the read |

## Verification
The assertions assume two things about the environment. First, the upstream master holds its request stable while `up_ready` is low. Second, the register block returns `dn_rdata` combinationally in the cycle of the read. The bench drives each request at the falling edge and keeps it unchanged until it has sampled `up_ready` high. Its register model answers reads from the current address without delay, so both assumptions hold throughout the sweeps.

// File: rtl/sw_merge_pkg.sv
package sw_merge_pkg;

    localparam int DATA_W    = 32;
    localparam int LANE_W    = 8;
    localparam int SHAMT_W   = $clog2(DATA_W);
    localparam int LANE_IDXW = $clog2(DATA_W / LANE_W);

    localparam logic [DATA_W-1:0] BYTE_FIELD = DATA_W'((1 << LANE_W) - 1);
    localparam logic [DATA_W-1:0] HALF_FIELD = DATA_W'((1 << (2 * LANE_W)) - 1);

    // word-index ranges of the register classes (read-only range starts at 0)
    localparam int RO_LAST     = 2;
    localparam int RW_FIRST    = 4;
    localparam int RW_LAST     = 11;
    localparam int W1C_FIRST   = 12;
    localparam int W1C_LAST    = 13;
    localparam int ALIAS_FIRST = 16;
    localparam int ALIAS_LAST  = 19;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        RC_NONE,
        RC_RO,
        RC_RW,
        RC_W1C,
        RC_ALIAS
    } reg_class_e;

    typedef enum logic {
        ST_IDLE,
        ST_WB
    } mrg_state_e;

    typedef struct packed {
        logic [DATA_W-1:0]  data;   // lane data placed at its position
        logic [DATA_W-1:0]  mask;   // lane bits at their position
        logic [SHAMT_W-1:0] shamt;  // lane offset in bits
        logic               ok;     // legal narrow access
    } lane_t;

    function automatic reg_class_e classify(input int widx);
        if (widx >= 0 && widx <= RO_LAST)                 return RC_RO;
        if (widx >= RW_FIRST && widx <= RW_LAST)          return RC_RW;
        if (widx >= W1C_FIRST && widx <= W1C_LAST)        return RC_W1C;
        if (widx >= ALIAS_FIRST && widx <= ALIAS_LAST)    return RC_ALIAS;
        return RC_NONE;
    endfunction

endpackage

// File: rtl/sw_lane_shift.sv
module sw_lane_shift
    import sw_merge_pkg::*;
(
    input  acc_size_e                size,
    input  logic [LANE_IDXW-1:0]     lane,
    input  logic [DATA_W-1:0]        wdata,
    output lane_t                    info
);

    logic [DATA_W-1:0]  field;
    logic [SHAMT_W-1:0] sh;

    always_comb begin
        field = '0;
        info.ok = 1'b0;
        unique case (size)
            SZ_BYTE: begin
                field   = BYTE_FIELD;
                info.ok = 1'b1;
            end
            SZ_HALF: begin
                field   = HALF_FIELD;
                info.ok = ~lane[0];
            end
            default: begin
                field   = '0;
                info.ok = 1'b0;
            end
        endcase
        sh         = SHAMT_W'(lane) << $clog2(LANE_W);
        info.shamt = sh;
        info.mask  = field << sh;
        info.data  = (wdata & field) << sh;
    end

endmodule

// File: rtl/sw_class_decode.sv
module sw_class_decode
    import sw_merge_pkg::*;
#(
    parameter int WIDX_W = 6
) (
    input  logic [WIDX_W-1:0] widx,
    output reg_class_e        cls
);

    always_comb cls = classify(int'(widx));

endmodule

// File: rtl/sw_rmw_ctrl.sv
module sw_rmw_ctrl
    import sw_merge_pkg::*;
#(
    parameter int WIDX_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                up_valid,
    input  logic                up_write,
    input  acc_size_e           up_size,
    input  logic [WIDX_W-1:0]   up_widx,
    input  logic [DATA_W-1:0]   up_wdata,
    input  lane_t               ln,
    input  reg_class_e          cls,
    input  logic [DATA_W-1:0]   dn_rdata,
    output logic                up_ready,
    output logic [DATA_W-1:0]   up_rdata,
    output logic                dn_valid,
    output logic                dn_write,
    output logic [WIDX_W-1:0]   dn_widx,
    output logic [DATA_W-1:0]   dn_wdata
);

    mrg_state_e          state_q, state_d;
    logic [WIDX_W-1:0]   hold_widx_q;
    logic [DATA_W-1:0]   hold_data_q;
    logic                capture;

    always_comb begin
        state_d  = state_q;
        capture  = 1'b0;
        up_ready = 1'b1;
        up_rdata = '0;
        dn_valid = 1'b0;
        dn_write = 1'b0;
        dn_widx  = up_widx;
        dn_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (up_valid) begin
                    if (up_size == SZ_WORD) begin
                        dn_valid = 1'b1;
                        dn_write = up_write;
                        dn_wdata = up_wdata;
                        up_rdata = dn_rdata;
                    end else if (ln.ok) begin
                        if (!up_write) begin
                            dn_valid = 1'b1;
                            up_rdata = dn_rdata >> ln.shamt;
                        end else begin
                            unique case (cls)
                                RC_RW: begin
                                    dn_valid = 1'b1;
                                    up_ready = 1'b0;
                                    capture  = 1'b1;
                                    state_d  = ST_WB;
                                end
                                RC_W1C, RC_ALIAS: begin
                                    dn_valid = 1'b1;
                                    dn_write = 1'b1;
                                    dn_wdata = ln.data;
                                end
                                default: ;
                            endcase
                        end
                    end
                end
            end
            ST_WB: begin
                dn_valid = 1'b1;
                dn_write = 1'b1;
                dn_widx  = hold_widx_q;
                dn_wdata = hold_data_q;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            hold_widx_q <= '0;
            hold_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                hold_widx_q <= up_widx;
                hold_data_q <= (dn_rdata & ~ln.mask) | ln.data;
            end
        end
    end

endmodule

// File: rtl/sw_merge_bridge.sv
module sw_merge_bridge
    import sw_merge_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic              up_write,
    input  logic [1:0]        up_size,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [31:0]       up_wdata,
    output logic              up_ready,
    output logic [31:0]       up_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [31:0]       dn_wdata,
    input  logic [31:0]       dn_rdata
);

    localparam int WIDX_W = ADDR_W - LANE_IDXW;

    acc_size_e          size_e;
    lane_t              ln;
    reg_class_e         cls;
    logic [WIDX_W-1:0]  dn_widx;

    assign size_e = acc_size_e'(up_size);

    sw_lane_shift u_lane (
        .size  (size_e),
        .lane  (up_addr[LANE_IDXW-1:0]),
        .wdata (up_wdata),
        .info  (ln)
    );

    sw_class_decode #(.WIDX_W(WIDX_W)) u_dec (
        .widx (up_addr[ADDR_W-1:LANE_IDXW]),
        .cls  (cls)
    );

    sw_rmw_ctrl #(.WIDX_W(WIDX_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .up_valid (up_valid),
        .up_write (up_write),
        .up_size  (size_e),
        .up_widx  (up_addr[ADDR_W-1:LANE_IDXW]),
        .up_wdata (up_wdata),
        .ln       (ln),
        .cls      (cls),
        .dn_rdata (dn_rdata),
        .up_ready (up_ready),
        .up_rdata (up_rdata),
        .dn_valid (dn_valid),
        .dn_write (dn_write),
        .dn_widx  (dn_widx),
        .dn_wdata (dn_wdata)
    );

    assign dn_addr = {dn_widx, {LANE_IDXW{1'b0}}};

endmodule

// File: rtl/sw_merge_chk.sv
module sw_merge_chk
    import sw_merge_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_write,
    input logic [1:0]        up_size,
    input logic [ADDR_W-1:0] up_addr,
    input logic [31:0]       up_wdata,
    input logic              up_ready,
    input logic [31:0]       up_rdata,
    input logic              dn_valid,
    input logic              dn_write,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [31:0]       dn_wdata,
    input logic [31:0]       dn_rdata
);

    logic        prev_stall;
    logic [31:0] fmask, lmask, sdata;
    logic [4:0]  sh;
    reg_class_e  cls_c;

    always_ff @(posedge clk) begin
        if (rst) prev_stall <= 1'b0;
        else     prev_stall <= up_valid && !up_ready;
    end

    always_comb begin
        fmask = (up_size == 2'd0) ? 32'h0000_00FF :
                (up_size == 2'd1) ? 32'h0000_FFFF : 32'h0;
        sh    = {up_addr[1:0], 3'b000};
        lmask = fmask << sh;
        sdata = (up_wdata & fmask) << sh;
        cls_c = classify(int'(up_addr[ADDR_W-1:2]));
    end

    a_r1_r5_read_first: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_ready) |-> (dn_valid && !dn_write));

    a_r5_write_next: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_ready) |=> (dn_valid && dn_write && up_ready &&
            dn_addr[ADDR_W-1:2] == $past(up_addr[ADDR_W-1:2])));

    a_r4_keep_outside: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_ready) |=>
            ((dn_wdata & ~$past(lmask)) == ($past(dn_rdata) & ~$past(lmask))));

    a_r4_lane_data: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_ready) |=> ((dn_wdata & $past(lmask)) == $past(sdata)));

    a_r6_r7_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (up_valid && dn_valid && dn_write && !prev_stall && up_size != 2'd2)
            |-> (up_ready && (dn_wdata & ~lmask) == 32'h0));

    a_r8_r9_only_action_regs: assert property (@(posedge clk) disable iff (rst)
        (up_valid && dn_valid && dn_write && !prev_stall && up_size != 2'd2)
            |-> (cls_c == RC_W1C || cls_c == RC_ALIAS));

    a_r2_pass_through: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_size == 2'd2 && !prev_stall) |->
            (up_ready && dn_valid && dn_write == up_write &&
             dn_addr[ADDR_W-1:2] == up_addr[ADDR_W-1:2] &&
             (!up_write || dn_wdata == up_wdata)));

    a_r10_r11_illegal_dropped: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !prev_stall && (up_size == 2'd3 || (up_size == 2'd1 && up_addr[0])))
            |-> (!dn_valid && up_ready && up_rdata == 32'h0));

endmodule

bind sw_merge_bridge sw_merge_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sw_merge_bridge_tb.sv
module sw_merge_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID_VAL  = 32'hA5C3_0118;
    localparam logic [31:0] STA_VAL = 32'h0000_0001;
    localparam logic [31:0] PIN_VAL = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_valid = 1'b0, up_write = 1'b0;
    logic [1:0]  up_size = 2'd0;
    logic [7:0]  up_addr = 8'h0;
    logic [31:0] up_wdata = 32'h0;
    logic        up_ready, dn_valid, dn_write;
    logic [31:0] up_rdata, dn_wdata, dn_rdata;
    logic [7:0]  dn_addr;

    int n_chk = 0, n_err = 0, wr_cnt = 0;
    logic [31:0] rw_m [8];
    logic [31:0] fl_m [2];
    logic [31:0] exp_rw [8];
    logic        seed_req = 1'b0;
    logic [31:0] seed_val = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_merge_bridge u_dut (.*);

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        int w;
        w = int'(a[7:2]);
        if (w == 0) return ID_VAL;
        if (w == 1) return STA_VAL;
        if (w == 2) return PIN_VAL;
        if (w >= 4 && w <= 11) return rw_m[w-4];
        if (w == 12 || w == 13) return fl_m[w-12];
        if (w == 16 || w == 17) return rw_m[0];
        if (w == 18 || w == 19) return rw_m[1];
        return 32'h0;
    endfunction

    always_comb dn_rdata = rd_model(dn_addr);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) rw_m[i] <= 32'h0;
            fl_m[0] <= 32'h0;
            fl_m[1] <= 32'h0;
        end else begin
            if (seed_req) begin
                fl_m[0] <= seed_val;
                fl_m[1] <= seed_val;
            end
            if (dn_valid && dn_write) begin
                int w;
                w = int'(dn_addr[7:2]);
                wr_cnt <= wr_cnt + 1;
                if (w >= 4 && w <= 11) rw_m[w-4] <= dn_wdata;
                else if (w == 12 || w == 13) fl_m[w-12] <= fl_m[w-12] & ~dn_wdata;
                else if (w == 16) rw_m[0] <= rw_m[0] | dn_wdata;
                else if (w == 17) rw_m[0] <= rw_m[0] & ~dn_wdata;
                else if (w == 18) rw_m[1] <= rw_m[1] | dn_wdata;
                else if (w == 19) rw_m[1] <= rw_m[1] & ~dn_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output int cyc);
        logic rdy;
        @(negedge clk);
        up_valid = 1'b1; up_write = wr; up_size = sz; up_addr = a; up_wdata = d;
        cyc = 0;
        forever begin
            #(CLK_PERIOD/4);
            rd  = up_rdata;
            rdy = up_ready;
            cyc++;
            @(posedge clk);
            if (rdy || cyc > 8) break;
            @(negedge clk);
        end
        #1 up_valid = 1'b0;
    endtask

    task automatic seed(input logic [31:0] v);
        @(negedge clk);
        seed_val = v; seed_req = 1'b1;
        @(posedge clk);
        #1 seed_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd, fm, base, d, exp;
        int cyc, c0, sh;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #(CLK_PERIOD/4);
        chk("R1 dn_valid idle", {31'h0, dn_valid}, 32'h0);
        chk("R1 up_ready idle", {31'h0, up_ready}, 32'h1);

        // R4/R5: sweep every read/write register, size and lane
        for (int w = 0; w < 8; w++) begin
            for (int sz = 0; sz < 2; sz++) begin
                for (int ln = 0; ln < 4; ln += (sz + 1)) begin
                    base = 32'h5A5A_5A5A ^ (w * 32'h0101_0101) ^ (ln << 20);
                    acc(1'b1, 2'd2, 8'(8'h10 + 4*w), base, rd, cyc);
                    if (w == 0 && sz == 0 && ln == 0) chk("R2 word write cycles", cyc, 1);
                    fm = (sz == 0) ? 32'hFF : 32'hFFFF;
                    sh = ln * 8;
                    d  = 32'hC3A5_0000 | (32'(w) << 12) | (32'(ln) << 8) | 32'h96 | 32'(sz);
                    acc(1'b1, 2'(sz), 8'(8'h10 + 4*w + ln), d, rd, cyc);
                    chk("R5 rmw cycles", cyc, 2);
                    exp = (base & ~(fm << sh)) | ((d & fm) << sh);
                    exp_rw[w] = exp;
                    acc(1'b0, 2'd2, 8'(8'h10 + 4*w), 32'h0, rd, cyc);
                    chk("R4 merged word", rd, exp);
                end
            end
        end

        // R3: narrow reads, byte and halfword, every lane
        for (int w = 0; w < 8; w++) begin
            for (int ln = 0; ln < 4; ln++) begin
                acc(1'b0, 2'd0, 8'(8'h10 + 4*w + ln), 32'h0, rd, cyc);
                chk("R3 byte read", rd, exp_rw[w] >> (ln * 8));
                if (ln % 2 == 0) begin
                    acc(1'b0, 2'd1, 8'(8'h10 + 4*w + ln), 32'h0, rd, cyc);
                    chk("R3 half read", rd, exp_rw[w] >> (ln * 8));
                end
            end
        end
        acc(1'b0, 2'd0, 8'h09, 32'h0, rd, cyc);
        chk("R3 read cycles", cyc, 1);
        chk("R3 read ro lane", rd, PIN_VAL >> 8);

        // R6: write-one-to-clear, zero fill keeps other flags set
        for (int f = 0; f < 2; f++) begin
            for (int ln = 0; ln < 4; ln++) begin
                seed(32'hFFFF_FFFF);
                d = 32'hFFFF_FF00 | 32'(8'h81 + 8'(ln));
                acc(1'b1, 2'd0, 8'(8'h30 + 4*f + ln), d, rd, cyc);
                chk("R6 w1c cycles", cyc, 1);
                acc(1'b0, 2'd2, 8'(8'h30 + 4*f), 32'h0, rd, cyc);
                chk("R6 w1c flags", rd, ~((d & 32'hFF) << (ln * 8)));
            end
        end
        seed(32'hFFFF_FFFF);
        acc(1'b1, 2'd1, 8'h32, 32'hFFFF_0F0F, rd, cyc);
        acc(1'b0, 2'd2, 8'h30, 32'h0, rd, cyc);
        chk("R6 w1c half", rd, 32'hF0F0_FFFF);

        // R7: set/clear aliases
        acc(1'b1, 2'd2, 8'h10, 32'h0F0F_0F0F, rd, cyc);
        acc(1'b1, 2'd0, 8'h41, 32'h0000_00F0, rd, cyc);
        chk("R7 alias cycles", cyc, 1);
        acc(1'b0, 2'd2, 8'h10, 32'h0, rd, cyc);
        chk("R7 alias set byte", rd, 32'h0F0F_FF0F);
        acc(1'b1, 2'd1, 8'h46, 32'hAAAA_0F0F, rd, cyc);
        acc(1'b0, 2'd2, 8'h10, 32'h0, rd, cyc);
        chk("R7 alias clear half", rd, 32'h0000_FF0F);
        acc(1'b1, 2'd2, 8'h14, 32'hFFFF_FFFF, rd, cyc);
        acc(1'b1, 2'd0, 8'h4F, 32'h0000_0081, rd, cyc);
        acc(1'b0, 2'd2, 8'h14, 32'h0, rd, cyc);
        chk("R7 alias clear top byte", rd, 32'h7EFF_FFFF);

        // R8: read-only targets receive no write
        for (int w = 0; w < 3; w++) begin
            c0 = wr_cnt;
            acc(1'b1, 2'd0, 8'(4*w + 1), 32'hFF, rd, cyc);
            chk("R8 ro write dropped", 32'(wr_cnt), 32'(c0));
        end
        acc(1'b0, 2'd2, 8'h08, 32'h0, rd, cyc);
        chk("R8 ro value", rd, PIN_VAL);

        // R9: unmapped targets
        c0 = wr_cnt;
        acc(1'b1, 2'd0, 8'h38, 32'h55, rd, cyc);
        chk("R9 unmapped cycles", cyc, 1);
        acc(1'b1, 2'd1, 8'h56, 32'h5555, rd, cyc);
        acc(1'b1, 2'd0, 8'hFF, 32'h55, rd, cyc);
        chk("R9 unmapped dropped", 32'(wr_cnt), 32'(c0));

        // R10: misaligned halfword
        c0 = wr_cnt;
        acc(1'b1, 2'd1, 8'h19, 32'hBEEF, rd, cyc);
        chk("R10 misaligned write dropped", 32'(wr_cnt), 32'(c0));
        chk("R10 misaligned cycles", cyc, 1);
        acc(1'b0, 2'd1, 8'h1B, 32'h0, rd, cyc);
        chk("R10 misaligned read zero", rd, 32'h0);
        acc(1'b0, 2'd2, 8'h18, 32'h0, rd, cyc);
        chk("R10 target unchanged", rd, exp_rw[2]);

        // R11: reserved size
        c0 = wr_cnt;
        acc(1'b1, 2'd3, 8'h20, 32'h1234, rd, cyc);
        chk("R11 reserved write dropped", 32'(wr_cnt), 32'(c0));
        acc(1'b0, 2'd3, 8'h20, 32'h0, rd, cyc);
        chk("R11 reserved read zero", rd, 32'h0);

        // R2: word pass-through, including a read-only offset
        c0 = wr_cnt;
        acc(1'b1, 2'd2, 8'h00, 32'h0, rd, cyc);
        chk("R2 word write to ro passes", 32'(wr_cnt), 32'(c0 + 1));
        acc(1'b1, 2'd2, 8'h2C, 32'hDEAD_BEEF, rd, cyc);
        acc(1'b0, 2'd2, 8'h2E, 32'h0, rd, cyc);
        chk("R2 word read aligned", rd, 32'hDEAD_BEEF);
        chk("R2 word read cycles", cyc, 1);

        finish_run();
    end

endmodule